// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block produces a single ATA programmed-I/O bus cycle, either a read or a write, each time it sees a start pulse. The cycle runs through four timed phases in a fixed order: address setup, strobe, write-data hold (writes only) and end-of-cycle recovery. Each phase length is a run-time value counted in clock ticks. The setup, hold and recovery values are read when their phase begins. The strobe value is read when the strobe phase begins. The direction and the ready-enable are captured at the start pulse.

The block drives active-high read and write strobes, an output enable for the data bus during writes, a one-clock read-data latch strobe and a one-clock done pulse. When ready stretching is enabled, the device ready input passes through a two-flop synchroniser and holds the strobe beyond its programmed width until the device reports ready. Surrounding logic chooses the timing values, decodes addresses, latches the read word on `rd_latch_o` and owns the bus pads.

Top module: `pio_cycle_seq`

## Requirements
- R1: With `rst_ni` low (asynchronous) or `clr_i` high at a clock edge (synchronous), the block returns to idle. In idle, `rd_stb_o`, `wr_stb_o`, `oe_o`, `rd_latch_o` and `done_o` are all low, and no done pulse follows.
- R2: A `go_i` sampled high in idle starts a cycle. Counting the clock cycle right after that edge as cycle 0, the strobe first asserts in cycle max(`t_setup_i`,1).
- R3: With ready stretching disabled, the strobe stays high for max(`t_strobe_i`,1) cycles. Only the strobe chosen by `dir_i` (1 = write → `wr_stb_o`, 0 = read → `rd_stb_o`) is ever asserted, and the two are never high together.
- R4: With `rdy_en_i` high at the start pulse, the strobe is not released before the synchronised ready is high. If `rdy_i` rises during cycle n, the last strobe cycle is max(setup+width−1, n+2).
- R5: With `rdy_en_i` low at the start pulse, `rdy_i` has no effect on the strobe length.
- R6: In a read, `rd_latch_o` is high for exactly one cycle: the last cycle in which `rd_stb_o` is high. It never rises in a write.
- R7: In a write, `oe_o` is high from cycle 0 through max(`t_hold_i`,1) cycles after the strobe ends. In a read, `oe_o` stays low.
- R8: After the strobe phase (or the hold phase, for writes), max(`t_recov_i`,1) recovery cycles follow. Then `done_o` pulses for exactly one cycle, and the block is idle in the next cycle.
- R9: A `go_i` that arrives while a cycle is in progress, including during the done cycle, is ignored.
- R10: A timing value of zero lasts one cycle, the same as a value of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start-of-cycle request, sampled in idle |
| dir_i | input | 1 | Direction: 1 write, 0 read |
| rdy_en_i | input | 1 | Enable ready stretching of the strobe |
| rdy_i | input | 1 | Device ready, asynchronous |
| t_setup_i | input | TW | Setup ticks before the strobe |
| t_strobe_i | input | TW | Minimum strobe ticks |
| t_hold_i | input | TW | Write data hold ticks after the strobe |
| t_recov_i | input | TW | End-of-cycle recovery ticks |
| rd_stb_o | output | 1 | Read strobe, active high |
| wr_stb_o | output | 1 | Write strobe, active high |
| oe_o | output | 1 | Data bus output enable for writes |
| rd_latch_o | output | 1 | Read data latch strobe |
| done_o | output | 1 | Cycle complete, one clock |

## Verification
Each result is due a fixed number of cycles after the clock edge that captures `go_i`. The strobe is due in cycle max(T1,1), the latch strobe and strobe release at the end of the strobe window, `oe_o` through the end of the hold phase, and done at setup+strobe(+hold)+recovery. A ready rise seen in cycle n takes effect in cycle n+2 after the two-flop synchroniser. The bench samples every output once per cycle on the falling edge, numbering the cycles from the capture edge. It compares the first and last strobe cycles, the pulse counts and the pulse positions against these formulas. Busy-time `go_i` pulses are applied at cycle 2 and at the done cycle; any restart would show up as extra strobe or done pulses before the window closes.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RECOV,
    ST_DONE
  } pio_state_e;
endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ff_q <= '0;
        else if (clr_i) ff_q <= '0;
        else            ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ff_q <= '0;
        else if (clr_i) ff_q <= '0;
        else            ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pio_tick_cnt.sv
module pio_tick_cnt #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // a phase of N ticks spans max(N,1) clocks: load N-1, expire at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= (val_i == '0) ? '0 : val_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_seq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic          dir_i,
  input  logic          rdy_en_i,
  input  logic          rdy_s_i,
  input  logic          cnt_zero_i,
  input  logic [TW-1:0] t_setup_i,
  input  logic [TW-1:0] t_strobe_i,
  input  logic [TW-1:0] t_hold_i,
  input  logic [TW-1:0] t_recov_i,
  output logic          load_o,
  output logic [TW-1:0] load_val_o,
  output pio_state_e    state_o,
  output logic          wr_o,
  output logic          strobe_end_o
);
  pio_state_e state_q, state_d;
  logic       wr_q, en_q;

  assign strobe_end_o = cnt_zero_i && (!en_q || rdy_s_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go_i) state_d = ST_SETUP;
      ST_SETUP:  if (cnt_zero_i) state_d = ST_STROBE;
      ST_STROBE: if (strobe_end_o) state_d = wr_q ? ST_HOLD : ST_RECOV;
      ST_HOLD:   if (cnt_zero_i) state_d = ST_RECOV;
      ST_RECOV:  if (cnt_zero_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP:  load_val_o = t_setup_i;
      ST_STROBE: load_val_o = t_strobe_i;
      ST_HOLD:   load_val_o = t_hold_i;
      default:   load_val_o = t_recov_i;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      en_q    <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go_i) begin
        wr_q <= dir_i;
        en_q <= rdy_en_i;
      end
    end
  end

  assign state_o = state_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic          dir_i,
  input  logic          rdy_en_i,
  input  logic          rdy_i,
  input  logic [TW-1:0] t_setup_i,
  input  logic [TW-1:0] t_strobe_i,
  input  logic [TW-1:0] t_hold_i,
  input  logic [TW-1:0] t_recov_i,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic          oe_o,
  output logic          rd_latch_o,
  output logic          done_o
);
  logic          rdy_s, cnt_zero, load, wr, strobe_end;
  logic [TW-1:0] load_val;
  pio_state_e    state;

  pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .d_i   (rdy_i),
    .q_o   (rdy_s)
  );

  pio_tick_cnt #(.TW(TW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .load_i(load),
    .val_i (load_val),
    .zero_o(cnt_zero)
  );

  pio_seq_fsm #(.TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .go_i        (go_i),
    .dir_i       (dir_i),
    .rdy_en_i    (rdy_en_i),
    .rdy_s_i     (rdy_s),
    .cnt_zero_i  (cnt_zero),
    .t_setup_i   (t_setup_i),
    .t_strobe_i  (t_strobe_i),
    .t_hold_i    (t_hold_i),
    .t_recov_i   (t_recov_i),
    .load_o      (load),
    .load_val_o  (load_val),
    .state_o     (state),
    .wr_o        (wr),
    .strobe_end_o(strobe_end)
  );

  // outputs decode straight from registered state
  assign rd_stb_o   = (state == ST_STROBE) && !wr;
  assign wr_stb_o   = (state == ST_STROBE) && wr;
  assign oe_o       = wr && (state == ST_SETUP || state == ST_STROBE || state == ST_HOLD);
  assign rd_latch_o = rd_stb_o && strobe_end;
  assign done_o     = (state == ST_DONE);
endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic rd_stb_o,
  input logic wr_stb_o,
  input logic oe_o,
  input logic rd_latch_o,
  input logic done_o
);
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !(rd_stb_o && wr_stb_o));

  assert_latch_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    rd_latch_o |-> rd_stb_o);

  assert_latch_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    rd_latch_o |=> !rd_stb_o);

  assert_oe_covers_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    wr_stb_o |-> oe_o);

  assert_oe_off_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    rd_stb_o |-> !oe_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    done_o |=> !done_o);

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    done_o |-> !(rd_stb_o || wr_stb_o || oe_o));

  assert_recov_before_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (rd_stb_o || wr_stb_o) |=> !done_o);
endmodule

bind pio_cycle_seq pio_cycle_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .rd_stb_o  (rd_stb_o),
  .wr_stb_o  (wr_stb_o),
  .oe_o      (oe_o),
  .rd_latch_o(rd_latch_o),
  .done_o    (done_o)
);

// File: tb/tb_pio_cycle_seq.sv
module tb_pio_cycle_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, clr_i = 1'b0, go_i = 1'b0, dir_i = 1'b0;
  logic rdy_en_i = 1'b0, rdy_i = 1'b0;
  logic [TW-1:0] t_setup_i = '0, t_strobe_i = '0, t_hold_i = '0, t_recov_i = '0;
  logic rd_stb_o, wr_stb_o, oe_o, rd_latch_o, done_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_seq #(.TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .go_i(go_i), .dir_i(dir_i),
    .rdy_en_i(rdy_en_i), .rdy_i(rdy_i), .t_setup_i(t_setup_i), .t_strobe_i(t_strobe_i),
    .t_hold_i(t_hold_i), .t_recov_i(t_recov_i), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
    .oe_o(oe_o), .rd_latch_o(rd_latch_o), .done_o(done_o)
  );

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {27'd0, rd_stb_o, wr_stb_o, oe_o, rd_latch_o, done_o}, 0);
  endtask

  // rdy_i rises at the sample point of cycle r (r=-1: together with go)
  task automatic run_cyc(input bit we, input int t1, input int t2, input int t4,
                         input int te, input bit en, input int r, input bit busy_go);
    int a, b, h, e, last, rs, done_c;
    int stb_first, stb_cnt, wrong_cnt, lat_cnt, lat_at, oe_cnt, oe_last, dn_cnt, dn_at;
    a = mx1(t1); b = mx1(t2); h = mx1(t4); e = mx1(te);
    last = a + b - 1;
    if (en && (r + 2 > last)) last = r + 2;
    rs = last + 1 + (we ? h : 0);
    done_c = rs + e;
    stb_first = -1; stb_cnt = 0; wrong_cnt = 0; lat_cnt = 0; lat_at = -1;
    oe_cnt = 0; oe_last = -1; dn_cnt = 0; dn_at = -1;

    rdy_i = 1'b0;
    repeat (3) @(negedge clk);
    dir_i = we; rdy_en_i = en;
    t_setup_i = TW'(t1); t_strobe_i = TW'(t2); t_hold_i = TW'(t4); t_recov_i = TW'(te);
    go_i = 1'b1;
    if (r < 0) rdy_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    for (int k = 0; k <= done_c + 3; k++) begin
      if (rd_stb_o || wr_stb_o) begin
        if (stb_first < 0) stb_first = k;
        stb_cnt++;
      end
      if ((we && rd_stb_o) || (!we && wr_stb_o)) wrong_cnt++;
      if (rd_latch_o) begin lat_cnt++; lat_at = k; end
      if (oe_o) begin oe_cnt++; oe_last = k; end
      if (done_o) begin dn_cnt++; dn_at = k; end
      if (k == r) rdy_i = 1'b1;
      go_i = busy_go && (k == 2 || k == done_c);
      @(negedge clk);
    end
    go_i = 1'b0;
    chk("R2/R10 strobe start", stb_first, a);
    chk("R3/R4/R5 strobe length", stb_cnt, last - a + 1);
    chk("R3 wrong strobe", wrong_cnt, 0);
    chk("R6 latch count", lat_cnt, we ? 0 : 1);
    if (!we) chk("R6 latch cycle", lat_at, last);
    chk("R7 oe count", oe_cnt, we ? last + h + 1 : 0);
    if (we) chk("R7 oe last", oe_last, last + h);
    chk("R8/R9 done count", dn_cnt, 1);
    chk("R8 done cycle", dn_at, done_c);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk_idle("R1 async reset idle");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 idle after reset");

    // directed: default timing, read and write
    run_cyc(1'b0, 6, 28, 2, 23, 1'b0, 0, 1'b0);
    run_cyc(1'b1, 6, 28, 2, 23, 1'b0, 0, 1'b0);
    // R10 zero values
    run_cyc(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    run_cyc(1'b1, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    // R4 ready stretch, late ready
    run_cyc(1'b0, 2, 3, 1, 2, 1'b1, 12, 1'b0);
    run_cyc(1'b1, 2, 3, 4, 2, 1'b1, 9, 1'b0);
    // R4 ready already high, no stretch
    run_cyc(1'b0, 3, 4, 1, 2, 1'b1, -1, 1'b0);
    // R5 ready ignored when disabled
    run_cyc(1'b0, 2, 3, 1, 2, 1'b0, 20, 1'b0);
    // R9 go while busy and during done
    run_cyc(1'b1, 3, 5, 2, 3, 1'b0, 0, 1'b1);
    run_cyc(1'b0, 1, 1, 1, 1, 1'b0, 0, 1'b1);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int t1, t2, t4, te, rr;
      bit we, en, bg;
      t1 = int'($urandom_range(0, 15)); t2 = int'($urandom_range(0, 15));
      t4 = int'($urandom_range(0, 15)); te = int'($urandom_range(0, 15));
      we = 1'($urandom_range(0, 1)); en = 1'($urandom_range(0, 1));
      bg = 1'($urandom_range(0, 1));
      rr = int'($urandom_range(0, 40)) - 1;
      run_cyc(we, t1, t2, t4, te, en, rr, bg);
    end

    // R1 synchronous clear mid-cycle
    dir_i = 1'b1; rdy_en_i = 1'b0;
    t_setup_i = 8'd2; t_strobe_i = 8'd10; t_hold_i = 8'd2; t_recov_i = 8'd3;
    go_i = 1'b1; @(negedge clk); go_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 strobe before clear", {31'd0, wr_stb_o}, 1);
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    chk_idle("R1 sync clear idle");
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 25; k++) begin
        if (wr_stb_o || rd_stb_o || oe_o || done_o) seen++;
        @(negedge clk);
      end
      chk("R1 no activity after clear", seen, 0);
    end

    // R1 asynchronous reset mid-cycle
    dir_i = 1'b0;
    go_i = 1'b1; @(negedge clk); go_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 read strobe before reset", {31'd0, rd_stb_o}, 1);
    #1 rst_ni = 1'b0;
    #1 chk_idle("R1 async reset mid-cycle");
    @(negedge clk); rst_ni = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 25; k++) begin
        if (wr_stb_o || rd_stb_o || oe_o || done_o) seen++;
        @(negedge clk);
      end
      chk("R1 no activity after reset", seen, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule